// File: doc/BRIEF.md
# Core Power Domain Sequencer

This block brings one of several processor-core power domains up or down in hardware. A request names a core, a direction (up or down) and, for power-down only, whether the core must first report that it is in standby. The sequencer then walks a fixed list of steps. Each step either changes one control bit of that core's domain, waits a number of microsecond ticks, or polls an acknowledge from the power switches, the L1 memory or the core. Only one sequence runs at a time. A request that arrives while a sequence is running is dropped.

Every core has a seven-bit control word. Bit 0 is the reset release (active low reset). Bit 1 is logic isolation. Bit 2 is the first-stage power switch and bit 3 the second-stage switch. Bit 4 is clock disable, bit 5 is memory clock isolation, and bit 6 releases memory isolation. Every core also has an L1 power-down request with a matching acknowledge. Two power status vectors report core n on bit 13 minus n. Core n's standby flag is bit 16 plus n of the standby vector. A poll that does not succeed after its bounded number of attempts ends the sequence with an error. The remaining steps are then left undone.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset every control word is 7'b0110010 (isolation, clock disable and memory clock isolation set; switches, reset release and memory isolation release clear). Every L1 power-down request is 1. busy, done and err are 0.
- R2: Power-up changes the selected core's bits in this order, each on its own clock: set bit 2, set bit 3, clear bit 1, clear the L1 request, set bit 6, clear bit 5, clear bit 4, set bit 0. Reset release is the last change, and done follows it.
- R3: Between setting bit 2 and setting bit 3 at least TICKS_PER_US tick pulses pass. The same wait separates the L1 acknowledge from setting bit 6.
- R4: Power-up waits until bit 13−n is high in both power status vectors. Power-down ends only when that bit is low in both vectors.
- R5: Power-down changes bits in this order: set bit 1, set bit 5, clear bit 6, set the L1 request, then wait for the L1 acknowledge to be high. It then clears bit 0, sets bit 4, clears bit 2, clears bit 3, and waits for the power status.
- R6: Each wait polls at most POLL_MAX times, with TICKS_PER_US ticks between polls. When the last poll fails, err pulses and no further bit changes.
- R7: On a power-down with the standby check on, the block first polls standby bit 16+n. If that wait times out, err pulses and no control bit changes. With the check off, standby is ignored.
- R8: busy is high from the cycle after a request is accepted until the sequence ends. Requests seen while busy are ignored. While idle, no control bit or L1 request changes. Only the selected core's bits change.
- R9: done (success) or err (failure) is high for exactly one cycle at the end of a sequence, never both at once. busy is low in that cycle.
- R10: At most one control or L1 request bit changes per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_on | input | 1 | 1 = power up, 0 = power down |
| req_core | input | 2 | Core index |
| req_stby | input | 1 | Check standby before power-down |
| pwr_sta_a | input | 16 | First power status vector, core n on bit 13−n |
| pwr_sta_b | input | 16 | Second power status vector, core n on bit 13−n |
| l1_ack | input | 4 | L1 power-down acknowledge per core |
| stby_sta | input | 32 | Standby status, core n on bit 16+n |
| ctl_word | output | 28 | Control words, core n at bits 7n+6..7n |
| l1_pdn_req | output | 4 | L1 power-down request per core |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle timeout pulse |

## Verification
The bench builds the block with TICKS_PER_US = 2 and drives one tick every five clocks. A delay that counts one tick too few therefore shows up in the measured tick spacing. POLL_MAX keeps its default of 10, so a full timeout takes about a hundred cycles. Error paths on each wait (first vector, second vector, L1 in both directions, power-down status, standby) can therefore all be run in one short test. Four cores let the bench check the mirrored status bit positions at both ends of the range.

// File: rtl/cps_pkg.sv
package cps_pkg;

  localparam int CTL_W = 7;

  localparam int B_RSTN  = 0;
  localparam int B_ISO   = 1;
  localparam int B_SW1   = 2;
  localparam int B_SW2   = 3;
  localparam int B_CKOFF = 4;
  localparam int B_MCKIS = 5;
  localparam int B_MREL  = 6;

  localparam logic [CTL_W-1:0] CTL_RST = 7'b0110010;

  typedef enum logic [2:0] {
    K_CTL, K_L1, K_DLY, K_WPWR, K_WL1, K_WSTBY, K_END
  } step_kind_e;

  typedef struct packed {
    step_kind_e kind;
    logic [2:0] bitn;
    logic       val;
  } step_t;

  function automatic step_t mk(input step_kind_e k, input int b, input logic v);
    step_t s;
    s.kind = k;
    s.bitn = 3'(b);
    s.val  = v;
    return s;
  endfunction

  // power-up program
  function automatic step_t up_step(input logic [3:0] i);
    case (i)
      4'd0:    return mk(K_CTL,  B_SW1,   1'b1);
      4'd1:    return mk(K_DLY,  0,       1'b0);
      4'd2:    return mk(K_CTL,  B_SW2,   1'b1);
      4'd3:    return mk(K_WPWR, 0,       1'b1);
      4'd4:    return mk(K_CTL,  B_ISO,   1'b0);
      4'd5:    return mk(K_L1,   0,       1'b0);
      4'd6:    return mk(K_WL1,  0,       1'b0);
      4'd7:    return mk(K_DLY,  0,       1'b0);
      4'd8:    return mk(K_CTL,  B_MREL,  1'b1);
      4'd9:    return mk(K_CTL,  B_MCKIS, 1'b0);
      4'd10:   return mk(K_CTL,  B_CKOFF, 1'b0);
      4'd11:   return mk(K_CTL,  B_RSTN,  1'b1);
      default: return mk(K_END,  0,       1'b0);
    endcase
  endfunction

  // power-down program
  function automatic step_t dn_step(input logic [3:0] i);
    case (i)
      4'd0:    return mk(K_WSTBY, 0,       1'b1);
      4'd1:    return mk(K_CTL,   B_ISO,   1'b1);
      4'd2:    return mk(K_CTL,   B_MCKIS, 1'b1);
      4'd3:    return mk(K_CTL,   B_MREL,  1'b0);
      4'd4:    return mk(K_L1,    0,       1'b1);
      4'd5:    return mk(K_WL1,   0,       1'b1);
      4'd6:    return mk(K_CTL,   B_RSTN,  1'b0);
      4'd7:    return mk(K_CTL,   B_CKOFF, 1'b1);
      4'd8:    return mk(K_CTL,   B_SW1,   1'b0);
      4'd9:    return mk(K_CTL,   B_SW2,   1'b0);
      4'd10:   return mk(K_WPWR,  0,       1'b0);
      default: return mk(K_END,   0,       1'b0);
    endcase
  endfunction

endpackage

// File: rtl/cps_tick_wait.sv
module cps_tick_wait #(
  parameter int N = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  output logic expire
);
  localparam int TW = $clog2(N + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!active)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_q + TW'(1);
  end

  // the N-th tick seen while active ends the wait at this edge
  assign expire = active && tick && (cnt_q == TW'(N - 1));

endmodule

// File: rtl/cps_ctl_bank.sv
module cps_ctl_bank
  import cps_pkg::*;
#(
  parameter int NCORE = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(NCORE)-1:0]   wr_core,
  input  logic [2:0]                 wr_bit,
  input  logic                       wr_val,
  input  logic                       l1_en,
  input  logic                       l1_val,
  output logic [NCORE*CTL_W-1:0]     ctl_flat,
  output logic [NCORE-1:0]           l1_req
);
  localparam int CW = $clog2(NCORE);

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    logic [CTL_W-1:0] word_q;
    logic             l1_q;
    logic             sel;

    assign sel = (wr_core == CW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= CTL_RST;
        l1_q   <= 1'b1;
      end else begin
        if (wr_en && sel)
          word_q[wr_bit] <= wr_val;
        if (l1_en && sel)
          l1_q <= l1_val;
      end
    end

    assign ctl_flat[g*CTL_W +: CTL_W] = word_q;
    assign l1_req[g] = l1_q;
  end

endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
  import cps_pkg::*;
#(
  parameter int NCORE     = 4,
  parameter int POLL_MAX  = 10,
  parameter int STAT_W    = 16,
  parameter int STAT_TOP  = 13,
  parameter int STBY_W    = 32,
  parameter int STBY_BASE = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_on,
  input  logic [$clog2(NCORE)-1:0] req_core,
  input  logic                     req_stby,
  input  logic [STAT_W-1:0]        pwr_sta_a,
  input  logic [STAT_W-1:0]        pwr_sta_b,
  input  logic [NCORE-1:0]         l1_ack,
  input  logic [STBY_W-1:0]        stby_sta,
  input  logic                     wait_done,
  output logic                     wait_active,
  output logic                     wr_en,
  output logic [$clog2(NCORE)-1:0] wr_core,
  output logic [2:0]               wr_bit,
  output logic                     wr_val,
  output logic                     l1_en,
  output logic                     l1_val,
  output logic                     busy,
  output logic                     done,
  output logic                     err,
  output logic                     ev_timeout
);
  localparam int CW  = $clog2(NCORE);
  localparam int PW  = $clog2(POLL_MAX + 1);
  localparam int SAW = $clog2(STAT_W);
  localparam int SBW = $clog2(STBY_W);

  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_DLY, S_GAP} st_e;

  function automatic logic [SAW-1:0] stat_pos(input logic [CW-1:0] c);
    return SAW'(STAT_TOP - int'(c));
  endfunction

  function automatic logic [SBW-1:0] stby_pos(input logic [CW-1:0] c);
    return SBW'(STBY_BASE + int'(c));
  endfunction

  st_e           state_q;
  logic [3:0]    step_q;
  logic          dir_q;
  logic [CW-1:0] core_q;
  logic          stby_q;
  logic [PW-1:0] polls_q;
  logic          done_q, err_q;

  step_t         cur;
  logic          in_exec, is_wait, cond_met, poll_last;
  logic          pa, pb;
  logic          unused_in;

  assign unused_in = ^{pwr_sta_a, pwr_sta_b, stby_sta};

  always_comb cur = dir_q ? up_step(step_q) : dn_step(step_q);

  assign pa = pwr_sta_a[stat_pos(core_q)];
  assign pb = pwr_sta_b[stat_pos(core_q)];

  always_comb begin
    is_wait  = 1'b0;
    cond_met = 1'b0;
    case (cur.kind)
      K_WPWR: begin
        is_wait  = 1'b1;
        cond_met = dir_q ? (pa && pb) : (!pa && !pb);
      end
      K_WL1: begin
        is_wait  = 1'b1;
        cond_met = (l1_ack[core_q] == cur.val);
      end
      K_WSTBY: begin
        is_wait  = 1'b1;
        cond_met = !stby_q || stby_sta[stby_pos(core_q)];
      end
      default: ;
    endcase
  end

  assign in_exec     = (state_q == S_EXEC);
  assign poll_last   = (polls_q == PW'(POLL_MAX - 1));
  assign ev_timeout  = in_exec && is_wait && !cond_met && poll_last;
  assign wait_active = (state_q == S_DLY) || (state_q == S_GAP);

  assign wr_en   = in_exec && (cur.kind == K_CTL);
  assign wr_core = core_q;
  assign wr_bit  = cur.bitn;
  assign wr_val  = cur.val;
  assign l1_en   = in_exec && (cur.kind == K_L1);
  assign l1_val  = cur.val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      dir_q   <= 1'b0;
      core_q  <= '0;
      stby_q  <= 1'b0;
      polls_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            state_q <= S_EXEC;
            step_q  <= '0;
            dir_q   <= req_on;
            core_q  <= req_core;
            stby_q  <= req_stby;
            polls_q <= '0;
          end
        end
        S_EXEC: begin
          case (cur.kind)
            K_CTL, K_L1: step_q <= step_q + 4'd1;
            K_DLY:       state_q <= S_DLY;
            K_END: begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
            end
            default: begin
              if (cond_met) begin
                step_q  <= step_q + 4'd1;
                polls_q <= '0;
              end else if (poll_last) begin
                state_q <= S_IDLE;
                err_q   <= 1'b1;
              end else begin
                polls_q <= polls_q + PW'(1);
                state_q <= S_GAP;
              end
            end
          endcase
        end
        S_DLY: begin
          if (wait_done) begin
            step_q  <= step_q + 4'd1;
            state_q <= S_EXEC;
          end
        end
        default: begin
          if (wait_done)
            state_q <= S_EXEC;
        end
      endcase
    end
  end

  assign busy = (state_q != S_IDLE);
  assign done = done_q;
  assign err  = err_q;

endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import cps_pkg::*;
#(
  parameter int NCORE        = 4,
  parameter int TICKS_PER_US = 1,
  parameter int POLL_MAX     = 10,
  parameter int STAT_W       = 16,
  parameter int STAT_TOP     = 13,
  parameter int STBY_W       = 32,
  parameter int STBY_BASE    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     us_tick,
  input  logic                     req_valid,
  input  logic                     req_on,
  input  logic [$clog2(NCORE)-1:0] req_core,
  input  logic                     req_stby,
  input  logic [STAT_W-1:0]        pwr_sta_a,
  input  logic [STAT_W-1:0]        pwr_sta_b,
  input  logic [NCORE-1:0]         l1_ack,
  input  logic [STBY_W-1:0]        stby_sta,
  output logic [NCORE*CTL_W-1:0]   ctl_word,
  output logic [NCORE-1:0]         l1_pdn_req,
  output logic                     busy,
  output logic                     done,
  output logic                     err
);
  localparam int CW = $clog2(NCORE);

  logic          wait_active, wait_done;
  logic          wr_en, wr_val, l1_en, l1_val;
  logic [CW-1:0] wr_core;
  logic [2:0]    wr_bit;
  logic          ev_timeout;

  cps_fsm #(
    .NCORE(NCORE), .POLL_MAX(POLL_MAX), .STAT_W(STAT_W), .STAT_TOP(STAT_TOP),
    .STBY_W(STBY_W), .STBY_BASE(STBY_BASE)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_on(req_on), .req_core(req_core), .req_stby(req_stby),
    .pwr_sta_a(pwr_sta_a), .pwr_sta_b(pwr_sta_b), .l1_ack(l1_ack), .stby_sta(stby_sta),
    .wait_done(wait_done), .wait_active(wait_active),
    .wr_en(wr_en), .wr_core(wr_core), .wr_bit(wr_bit), .wr_val(wr_val),
    .l1_en(l1_en), .l1_val(l1_val),
    .busy(busy), .done(done), .err(err), .ev_timeout(ev_timeout)
  );

  cps_tick_wait #(.N(TICKS_PER_US)) u_wait (
    .clk(clk), .rst_n(rst_n), .active(wait_active), .tick(us_tick), .expire(wait_done)
  );

  cps_ctl_bank #(.NCORE(NCORE)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_core(wr_core), .wr_bit(wr_bit), .wr_val(wr_val),
    .l1_en(l1_en), .l1_val(l1_val),
    .ctl_flat(ctl_word), .l1_req(l1_pdn_req)
  );

endmodule

// File: rtl/cps_chk.sv
module cps_chk
  import cps_pkg::*;
#(
  parameter int NCORE = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   done,
  input logic                   err,
  input logic                   ev_timeout,
  input logic [NCORE*CTL_W-1:0] ctl_word,
  input logic [NCORE-1:0]       l1_pdn_req
);
  logic [NCORE*CTL_W+NCORE-1:0] all_bits;
  logic [NCORE-1:0]             rstb;

  assign all_bits = {ctl_word, l1_pdn_req};
  for (genvar g = 0; g < NCORE; g++) begin : g_rb
    assign rstb[g] = ctl_word[g*CTL_W + B_RSTN];
  end

  // R10: one bit change per clock at most
  a_r10_one_change: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(all_bits ^ $past(all_bits)) <= 1);

  // R8: nothing moves while idle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(all_bits));

  // R9: end pulse with busy low, one cycle, exclusive
  a_r9_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (!busy && !(done && err)));

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |=> !(done || err));

  // R2: reset release is the final power-up change
  a_r2_rst_last: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rstb & ~$past(rstb))) |=> done);

  // R6: an error is always preceded by a final failed poll
  a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(ev_timeout));

endmodule

bind core_pwr_seq cps_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .ev_timeout(ev_timeout), .ctl_word(ctl_word), .l1_pdn_req(l1_pdn_req)
);

// File: tb/core_pwr_seq_tb.sv
module core_pwr_seq_tb;
  // time unit taken as 1 ns: 4 ns period, 250 MHz
  localparam int NC = 4;
  localparam int TPU = 2;
  localparam int PM = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        us_tick = 1'b0;
  logic        req_valid = 1'b0, req_on = 1'b0, req_stby = 1'b0;
  logic [1:0]  req_core = 2'd0;
  logic [15:0] pwr_sta_a, pwr_sta_b;
  logic [3:0]  l1_ack;
  logic [31:0] stby_sta = '0;
  logic [27:0] ctl_word;
  logic [3:0]  l1_pdn_req;
  logic        busy, done, err;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  core_pwr_seq #(.NCORE(NC), .TICKS_PER_US(TPU), .POLL_MAX(PM)) u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .req_valid(req_valid), .req_on(req_on),
    .req_core(req_core), .req_stby(req_stby), .pwr_sta_a(pwr_sta_a), .pwr_sta_b(pwr_sta_b),
    .l1_ack(l1_ack), .stby_sta(stby_sta), .ctl_word(ctl_word), .l1_pdn_req(l1_pdn_req),
    .busy(busy), .done(done), .err(err)
  );

  // tick every 5 clocks
  int tdiv = 0;
  always @(posedge clk) begin
    tdiv <= (tdiv == 4) ? 0 : tdiv + 1;
    us_tick <= (tdiv == 4);
  end

  // responder: status follows switches, L1 ack follows request, unless held
  logic [3:0] hold_a = '0, hold_b = '0, hold_l = '0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_sta_a <= '0; pwr_sta_b <= '0; l1_ack <= 4'hF;
    end else begin
      for (int n = 0; n < NC; n++) begin
        if (!hold_a[n]) pwr_sta_a[13-n] <= ctl_word[n*7+2];
        if (!hold_b[n]) pwr_sta_b[13-n] <= ctl_word[n*7+3];
        if (!hold_l[n]) l1_ack[n] <= l1_pdn_req[n];
      end
    end
  end

  // monitor: log bit changes (code 0..6 ctl bits, 7 = L1 request)
  logic [27:0] prev_w;
  logic [3:0]  prev_l;
  int act_core = 0, ev_n = 0, foreign = 0, multi = 0, tick_cnt = 0, err_tick = 0;
  int ev_code [16];
  int ev_tick [16];
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_w = ctl_word; prev_l = l1_pdn_req;
    end else begin
      int nchg;
      nchg = 0;
      for (int n = 0; n < NC; n++) begin
        for (int b = 0; b < 8; b++) begin
          logic cv, pv;
          cv = (b == 7) ? l1_pdn_req[n] : ctl_word[n*7+b];
          pv = (b == 7) ? prev_l[n] : prev_w[n*7+b];
          if (cv != pv) begin
            nchg++;
            if (n == act_core && ev_n < 16) begin
              ev_code[ev_n] = b; ev_tick[ev_n] = tick_cnt; ev_n++;
            end else foreign++;
          end
        end
      end
      if (nchg > 1) multi++;
      if (err) err_tick = tick_cnt;
      tick_cnt += int'(us_tick);
      prev_w = ctl_word; prev_l = l1_pdn_req;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected order and resulting values
  localparam int UP_ORD [8] = '{2, 3, 1, 7, 6, 5, 4, 0};
  localparam int UP_VAL [8] = '{1, 1, 0, 0, 1, 0, 0, 1};
  localparam int DN_ORD [8] = '{1, 5, 6, 7, 0, 4, 2, 3};
  localparam int DN_VAL [8] = '{1, 1, 0, 1, 0, 1, 0, 0};

  logic [6:0] mdl_w [NC];
  logic       mdl_l [NC];

  task automatic mdl_reset();
    for (int n = 0; n < NC; n++) begin mdl_w[n] = 7'b0110010; mdl_l[n] = 1'b1; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    mdl_reset();
    @(negedge clk);
  endtask

  task automatic cmp_model(input string req);
    for (int n = 0; n < NC; n++) begin
      chk(ctl_word[n*7 +: 7] == mdl_w[n], req, int'(ctl_word[n*7 +: 7]), int'(mdl_w[n]));
      chk(l1_pdn_req[n] == mdl_l[n], req, int'(l1_pdn_req[n]), int'(mdl_l[n]));
    end
  endtask

  typedef struct packed {
    logic       rst;
    logic       on;
    logic [1:0] core;
    logic       sflag;
    logic       spres;
    logic [1:0] fault;   // 0 none, 1 hold vector a, 2 hold vector b, 3 hold L1 ack
    logic [3:0] nev;
    logic       exp_err;
  } row_t;

  localparam row_t ROWS [15] = '{
    '{1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 4'd8, 1'b0},
    '{1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 2'd0, 4'd8, 1'b0},
    '{1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd0, 4'd8, 1'b0},
    '{1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 4'd8, 1'b0},
    '{1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 2'd0, 4'd8, 1'b0},
    '{1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 2'd0, 4'd0, 1'b1},
    '{1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 2'd0, 4'd8, 1'b0},
    '{1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 2'd1, 4'd2, 1'b1},
    '{1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 2'd2, 4'd2, 1'b1},
    '{1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd3, 4'd4, 1'b1},
    '{1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 4'd8, 1'b0},
    '{1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 2'd3, 4'd4, 1'b1},
    '{1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 2'd0, 4'd8, 1'b0},
    '{1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 2'd2, 4'd8, 1'b1},
    '{1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 4'd8, 1'b0}
  };

  task automatic run_row(input int idx);
    row_t r;
    int c, lim, ord_bad;
    bit got_err, got_done, got_busy;
    r = ROWS[idx];
    c = int'(r.core);
    if (r.rst) do_reset();
    stby_sta[16+c] = r.spres;
    hold_a[c] = (r.fault == 2'd1);
    hold_b[c] = (r.fault == 2'd2);
    hold_l[c] = (r.fault == 2'd3);
    act_core = c; ev_n = 0; foreign = 0; multi = 0;
    req_valid = 1'b1; req_on = r.on; req_core = r.core; req_stby = r.sflag;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
    lim = 0;
    while (!(done || err) && lim < 3000) begin @(negedge clk); lim++; end
    got_err = err; got_done = done; got_busy = busy;
    chk(got_err == r.exp_err && got_done == !r.exp_err, "R6 outcome err",
        int'(got_err), int'(r.exp_err));
    chk(!got_busy, "R9 busy low at end", int'(got_busy), 0);
    @(negedge clk);
    chk(!done && !err, "R9 pulse width", int'(done || err), 0);
    chk(ev_n == int'(r.nev), r.on ? "R2 change count" : "R5 change count", ev_n, int'(r.nev));
    ord_bad = 0;
    for (int k = 0; k < int'(r.nev) && k < ev_n; k++) begin
      int code, val;
      code = r.on ? UP_ORD[k] : DN_ORD[k];
      val  = r.on ? UP_VAL[k] : DN_VAL[k];
      if (ev_code[k] != code) ord_bad++;
      if (code == 7) mdl_l[c] = val[0]; else mdl_w[c][code] = val[0];
    end
    chk(ord_bad == 0, r.on ? "R2 order" : "R5 order", ord_bad, 0);
    cmp_model(r.exp_err ? "R6 state after abort" : "R4 state after sequence");
    chk(foreign == 0, "R8 other cores untouched", foreign, 0);
    chk(multi == 0, "R10 single change per clock", multi, 0);
    if (idx == 0)
      chk(ev_tick[1] - ev_tick[0] >= TPU && ev_tick[1] - ev_tick[0] <= TPU + 1,
          "R3 switch spacing ticks", ev_tick[1] - ev_tick[0], TPU);
    if (idx == 7 || idx == 8)
      chk(err_tick - ev_tick[1] >= (PM-1)*TPU && err_tick - ev_tick[1] <= (PM-1)*TPU + 1,
          "R6 poll window ticks", err_tick - ev_tick[1], (PM-1)*TPU);
    if (idx == 13)
      chk(err_tick - ev_tick[7] >= (PM-1)*TPU && err_tick - ev_tick[7] <= (PM-1)*TPU + 1,
          "R4 down status window ticks", err_tick - ev_tick[7], (PM-1)*TPU);
    if (idx == 5)
      chk(ev_n == 0, "R7 no change on standby timeout", ev_n, 0);
    hold_a = '0; hold_b = '0; hold_l = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int dones, busy_late;
    mdl_reset();
    repeat (3) @(negedge clk);
    // R1: reset state, sampled while reset is still held and just after release
    for (int n = 0; n < NC; n++)
      chk(ctl_word[n*7 +: 7] == 7'b0110010 && l1_pdn_req[n], "R1 reset word",
          int'(ctl_word[n*7 +: 7]), 7'b0110010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err, "R1 flags at reset", int'({busy, done, err}), 0);
    cmp_model("R1 reset state");

    for (int i = 0; i < 15; i++) run_row(i);

    // R8: requests while busy are dropped
    do_reset();
    act_core = 1; ev_n = 0; foreign = 0; multi = 0;
    req_valid = 1'b1; req_on = 1'b1; req_core = 2'd1; req_stby = 1'b0;
    @(negedge clk);
    req_on = 1'b0; req_core = 2'd0;
    @(negedge clk);
    req_on = 1'b1; req_core = 2'd2;
    @(negedge clk);
    req_valid = 1'b0;
    dones = 0; busy_late = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (done) dones++;
      if (k > 300 && busy) busy_late++;
    end
    chk(dones == 1, "R8 one sequence only", dones, 1);
    chk(busy_late == 0, "R8 no queued sequence", busy_late, 0);
    chk(foreign == 0, "R8 ignored requests left other cores", foreign, 0);
    chk(ev_n == 8, "R8 selected core completed", ev_n, 8);
    for (int n = 0; n < NC; n += 2)
      chk(ctl_word[n*7 +: 7] == 7'b0110010 && l1_pdn_req[n], "R8 dropped core unchanged",
          int'(ctl_word[n*7 +: 7]), 7'b0110010);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule